// File: doc/BRIEF.md
# Switch Population Count Digit Driver

This block reads a row of eight active-low switches, works out how many of them are closed, and lights one seven-segment digit with that number (0 to 8). Each switch line is inverted first, so a pulled-low line counts as a one. A fixed tree of four small ripple adders produces the 4-bit count. A lookup then turns the count straight into a segment byte. There is no BCD-to-segment stage in between.

The block can be dropped into a clocked design. A parameter adds a register on the switch inputs, and another adds a register on the outputs. The 4-bit count leaves the block next to the segment byte, with the same timing, so the count can be observed on its own.

Top module: `popseg_display`

## Requirements
- R1: Each bit of `sw_n` is active-low: a 0 on bit i means switch i is closed and adds one to the count, and a 1 adds nothing.
- R2: `count` equals the number of zero bits in `sw_n`, from 0 to 8. For example `sw_n` = 8'b0010_0110 (five closed switches) gives `count` = 5.
- R3: The count is formed by an adder tree in three levels. Level one is two 1-bit full adders, one on closed-flags [2:0] and one on [5:3]. Level two is a 2-bit adder with closed-flag 6 as its carry-in. Level three is a 3-bit adder with closed-flag 7 as its carry-in, and it gives the 4-bit result.
- R4: `seg` layout: bit 7 is segment a, bit 6 is b, bit 5 is c, bit 4 is d, bit 3 is e, bit 2 is f, bit 1 is g, and bit 0 is the decimal point. A 1 lights a segment.
- R5: The decimal point, `seg[0]`, is always 0.
- R6: For counts 0 to 8, `seg` is 8'hFC, 8'h60, 8'hDA, 8'hF2, 8'h66, 8'hB6, 8'hBE, 8'hE0, 8'hFE in that order.
- R7: With `REG_IN` and `REG_OUT` both 1 (the default), `seg` and `count` show the `sw_n` value that was present two rising clock edges earlier. Each register left out removes one cycle. Back-to-back inputs produce back-to-back results.
- R8: While `rst_n` is low at a rising edge, the input register loads all ones (every switch open) and the output register loads `count` = 0 and `seg` = 8'hFC, whatever `sw_n` is.
- R9: `count` and `seg` always describe the same input sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional registers |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_n | input | 8 | Switch lines, low when a switch is closed |
| seg | output | 8 | Segment byte a..g, dp in bit 0, active-high |
| count | output | 4 | Number of closed switches |

## Verification
The assertions assume that `sw_n` is a clean two-level value, sampled once per clock, with no X bits. They also assume that the count reaching the segment lookup never goes above 8, which an 8-input tree guarantees. The stimulus stays within these limits. It changes `sw_n` only on falling edges. It uses only fully defined byte values: the whole 256-value space, a seeded random stream and hand-picked corners. It never puts an unknown value on the switch lines.

// File: rtl/popseg_pkg.sv
// Package: shared widths and the count-to-segment mapping for the
// population count digit driver. Assumes one digit, active-high segments.
package popseg_pkg;

    localparam int SW_W    = 8;   // switch lines
    localparam int CNT_W   = 4;   // enough for 0..8
    localparam int SEG_W   = 8;   // a..g plus decimal point
    localparam int CNT_MAX = SW_W;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [SEG_W-1:0] seg_t;

    localparam seg_t SEG_BLANK = '0;

    // Map a count straight to a segment byte (a in bit 7, dp in bit 0).
    function automatic seg_t count_to_seg(input count_t c);
        seg_t s;
        case (c)
            4'd0:    s = 8'hFC;
            4'd1:    s = 8'h60;
            4'd2:    s = 8'hDA;
            4'd3:    s = 8'hF2;
            4'd4:    s = 8'h66;
            4'd5:    s = 8'hB6;
            4'd6:    s = 8'hBE;
            4'd7:    s = 8'hE0;
            4'd8:    s = 8'hFE;
            default: s = SEG_BLANK;   // unreachable count: all dark
        endcase
        return s;
    endfunction

endpackage

// File: rtl/popseg_rca.sv
// Module: W-bit ripple-carry adder with carry-in, giving a W+1 bit sum.
// Assumes nothing about its operands; purely combinational.
module popseg_rca #(
    parameter int W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   sum
);

    logic [W:0] carry;

    assign carry[0] = cin;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign sum[W] = carry[W];

endmodule

// File: rtl/popseg_count_tree.sv
// Module: counts the ones in an 8-bit word with a fixed tree of four
// ripple adders (1-bit, 1-bit, 2-bit, 3-bit). Assumes active-high flags.
module popseg_count_tree
    import popseg_pkg::*;
(
    input  logic [SW_W-1:0] flags,
    output count_t          total
);

    localparam int L1_W = 1;
    localparam int L2_W = L1_W + 1;
    localparam int L3_W = L2_W + 1;

    logic [L1_W:0] sum_lo;
    logic [L1_W:0] sum_mid;
    logic [L2_W:0] sum_six;
    logic [L3_W:0] sum_all;

    // Level one: flags [2:0], two as operands and one as carry-in.
    popseg_rca #(.W(L1_W)) u_l1_lo (
        .a(flags[0]), .b(flags[1]), .cin(flags[2]), .sum(sum_lo)
    );

    // Level one: flags [5:3].
    popseg_rca #(.W(L1_W)) u_l1_mid (
        .a(flags[3]), .b(flags[4]), .cin(flags[5]), .sum(sum_mid)
    );

    // Level two: join both partial sums, flag 6 rides the carry-in.
    popseg_rca #(.W(L2_W)) u_l2 (
        .a(sum_lo), .b(sum_mid), .cin(flags[6]), .sum(sum_six)
    );

    // Level three: flag 7 rides the carry-in of the widest stage.
    popseg_rca #(.W(L3_W)) u_l3 (
        .a(sum_six), .b('0), .cin(flags[7]), .sum(sum_all)
    );

    assign total = count_t'(sum_all);

endmodule

// File: rtl/popseg_seg_map.sv
// Module: turns a count into a segment byte without a BCD stage.
// Assumes the count is 0..8; anything larger is shown dark.
module popseg_seg_map
    import popseg_pkg::*;
(
    input  count_t cnt,
    output seg_t   seg
);

    // Direct lookup of the segment pattern.
    always_comb begin
        seg = count_to_seg(cnt);
    end

endmodule

// File: rtl/popseg_display.sv
// Module: top of the population count digit driver. Inverts the
// active-low switch lines, counts closed switches, maps to segments.
// Optional input and output registers are set by REG_IN / REG_OUT.
// Assumes sw_n is synchronous to clk when REG_IN is 1.
module popseg_display
    import popseg_pkg::*;
#(
    parameter bit REG_IN  = 1'b1,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_W-1:0] sw_n,
    output logic [SEG_W-1:0] seg,
    output logic [CNT_W-1:0] count
);

    logic [SW_W-1:0] sw_n_s;
    logic [SW_W-1:0] closed;
    count_t          cnt_c;
    seg_t            seg_c;

    // Optional input stage.
    if (REG_IN) begin : g_in_reg
        logic [SW_W-1:0] sw_q;
        // Capture switch lines; reset means every switch open.
        always_ff @(posedge clk) begin
            if (!rst_n) sw_q <= '1;
            else        sw_q <= sw_n;
        end
        assign sw_n_s = sw_q;
    end else begin : g_in_wire
        assign sw_n_s = sw_n;
    end

    // Active-low lines become active-high closed flags.
    assign closed = ~sw_n_s;

    popseg_count_tree u_tree (
        .flags(closed),
        .total(cnt_c)
    );

    popseg_seg_map u_map (
        .cnt(cnt_c),
        .seg(seg_c)
    );

    // Optional output stage.
    if (REG_OUT) begin : g_out_reg
        count_t cnt_q;
        seg_t   seg_q;
        // Hold count and segments together; reset shows digit zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                seg_q <= count_to_seg('0);
            end else begin
                cnt_q <= cnt_c;
                seg_q <= seg_c;
            end
        end
        assign count = cnt_q;
        assign seg   = seg_q;

        AST_OUT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (seg == $past(seg_c)) && (count == $past(cnt_c))); // R7
    end else begin : g_out_wire
        assign count = cnt_c;
        assign seg   = seg_c;
    end

    AST_TREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_c == CNT_W'($countones(closed))); // R3

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= count_t'(CNT_MAX)); // R2

    AST_DP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        seg[0] == 1'b0); // R5

    AST_ZERO_GLYPH: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (seg == 8'hFC)); // R9

    AST_ALL_LIT_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == 8'hFE) |-> (count == 4'd8)); // R6

endmodule

// File: tb/popseg_display_tb.sv
// Bench for popseg_display with default parameters (two-cycle latency).
module popseg_display_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sw_n = 8'hFF;
    logic [7:0] seg;
    logic [3:0] count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    popseg_display dut_i (
        .clk(clk), .rst_n(rst_n), .sw_n(sw_n), .seg(seg), .count(count)
    );

    function automatic logic [3:0] ref_count(input logic [7:0] v);
        logic [3:0] n = '0;
        for (int i = 0; i < 8; i++) if (v[i] == 1'b0) n++;
        return n;
    endfunction

    function automatic logic [7:0] ref_seg(input logic [3:0] c);
        case (c)
            4'd0: return 8'hFC;  4'd1: return 8'h60;  4'd2: return 8'hDA;
            4'd3: return 8'hF2;  4'd4: return 8'h66;  4'd5: return 8'hB6;
            4'd6: return 8'hBE;  4'd7: return 8'hE0;  4'd8: return 8'hFE;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check outputs against the value applied two edges ago.
    task automatic check_for(input logic [7:0] v, input string req);
        check({req, " count"}, {4'd0, count}, {4'd0, ref_count(v)});
        check({req, " seg"}, seg, ref_seg(ref_count(v)));
        check("R5 dp", {7'd0, seg[0]}, 8'd0);
    endtask

    task automatic apply(input logic [7:0] v, input string req);
        @(negedge clk) sw_n = v;
        @(posedge clk); @(posedge clk);
        @(negedge clk) check_for(v, req);
    endtask

    initial begin
        logic [7:0] hist [0:2];
        void'($urandom(32'h5EED_0001));
        // R8: reset dominates even with every switch closed.
        sw_n = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset count", {4'd0, count}, 8'd0);
        check("R8 reset seg", seg, 8'hFC);
        @(negedge clk) rst_n = 1'b1;

        // R2: worked example, five closed switches.
        apply(8'b0010_0110, "R2 example");
        // R1: all open and all closed corners.
        apply(8'hFF, "R1 all open");
        apply(8'h00, "R1 all closed");
        apply(8'hFE, "R1 bit0 closed");
        apply(8'h7F, "R1 bit7 closed");
        // R3: exercise each adder input in turn.
        for (int i = 0; i < 8; i++) apply(~(8'h01 << i), "R3 single");
        // R4 and R6: every pattern, every count glyph.
        for (int v = 0; v < 256; v++) apply(8'(v), "R6 exhaustive");
        apply(8'b1111_0000, "R4 four closed");
        // R9: random values, count and seg stay paired.
        for (int k = 0; k < 200; k++) apply(8'($urandom), "R9 random");

        // R7: back-to-back stream, result lags two cycles.
        hist[0] = 8'hFF; hist[1] = 8'hFF; hist[2] = 8'hFF;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (k >= 2) check_for(hist[2], "R7 stream");
            sw_n = 8'($urandom);
            hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = sw_n;
            @(posedge clk);
            hist[2] = hist[1]; hist[1] = hist[0];
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule